// File: doc/BRIEF.md
# 8-bit ALU with Status Flag Update

This block is the combinational arithmetic and logic stage of a small 8-bit RISC core. Each call takes two operands, an incoming carry, an operation code and the current status byte. In the same cycle it returns an 8-bit result, the next status byte and a per-bit write mask. The mask shows which status bits this operation owns. Every other bit of the status byte passes through from the input unchanged, so the surrounding core can write the returned status byte back whole.

The operations are:
- add and subtract, each with or without carry;
- negate (two's complement);
- AND, OR and XOR;
- one's complement;
- increment and decrement;
- logical shifts left and right;
- rotates left and right through carry;
- arithmetic shift right;
- nibble swap.

Subtract-with-carry can only clear the zero flag. A compare spread over several bytes therefore reports equality only when every byte matched.

Top module: `alu8_core`

## Requirements
- R1: Operation codes on `op` are: add 0, add-with-carry 1, subtract 2, subtract-with-carry 3, negate 4, AND 5, OR 6, XOR 7, one's complement 8, increment 9, decrement 10, shift left 11, shift right 12, rotate left 13, rotate right 14, arithmetic shift right 15, swap 16. Status bit positions are C=0, Z=1, N=2, V=3, S=4, H=5, T=6, I=7. Every status bit whose `flag_we` bit is 0 equals the same bit of `status_in`.
- R2: Add (carry in taken only for code 1) gives A+B(+cin) modulo 256. C is the carry out of bit 7, H the carry out of bit 3, and V is set on signed overflow. The mask is 0x3F.
- R3: Subtract, subtract-with-carry and negate give A-B(-cin) and 0-A respectively. C is the borrow out of bit 7, H the borrow into bit 4 from bit 3, and V is set on signed overflow. The mask is 0x3F.
- R4: For subtract-with-carry, Z is 1 only when the result is zero and `status_in` Z was 1. For every other flag-writing operation, Z is 1 exactly when the result is zero.
- R5: AND, OR and XOR clear V and write only S, V, N and Z (mask 0x1E).
- R6: Increment sets V only when A was 0x7F, decrement only when A was 0x80. Both use mask 0x1E.
- R7: One's complement returns 0xFF-A, sets C to 1 and clears V (mask 0x1F).
- R8: The shift operations produce these results and carries:
  - Shift left inserts 0 at bit 0; shift right inserts 0 at bit 7.
  - Rotate left moves cin into bit 0; rotate right moves cin into bit 7.
  - Arithmetic shift right keeps bit 7.
  - Left moves put old bit 7 into C; right moves put old bit 0 into C.
  - Mask 0x1F.
- R9: After any shift or rotate, V equals N XOR C.
- R10: Wherever S is written, S equals N XOR V, and N equals result bit 7.
- R11: Swap exchanges the two nibbles of A and writes no flag (mask 0).
- R12: Codes 17 to 31 give result 0 and mask 0.
- R13: Bits T and I are never written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op | input | 5 | Operation code (R1) |
| op_a | input | 8 | First operand, also the only operand of unary operations |
| op_b | input | 8 | Second operand |
| carry_in | input | 1 | Carry used by add/subtract with carry and by rotates |
| status_in | input | 8 | Current status byte |
| result | output | 8 | Operation result |
| status_out | output | 8 | Next status byte |
| flag_we | output | 8 | Per-bit mask of status bits written by this operation |

## Verification
The block holds no state, so a fault in its internal selection or flag logic shows at the ports in the same evaluation. The symptoms are a wrong result, a flag taken from the wrong source, or a mask that lets a preserved bit change. The bench applies one vector per clock and compares all three outputs against a behavioural model before the next vector arrives. Chained subtract-with-carry vectors expose a zero flag that fails to propagate, because Z is wrong on the very next compare.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int OPW = 5;
  localparam int SW  = 8;

  typedef enum logic [OPW-1:0] {
    OP_ADD  = 5'd0,  OP_ADC  = 5'd1,  OP_SUB  = 5'd2,  OP_SBC  = 5'd3,
    OP_NEG  = 5'd4,  OP_AND  = 5'd5,  OP_OR   = 5'd6,  OP_XOR  = 5'd7,
    OP_COM  = 5'd8,  OP_INC  = 5'd9,  OP_DEC  = 5'd10, OP_LSL  = 5'd11,
    OP_LSR  = 5'd12, OP_ROL  = 5'd13, OP_ROR  = 5'd14, OP_ASR  = 5'd15,
    OP_SWAP = 5'd16
  } alu_op_e;

  // status bit positions, decoded by the core's branch and flag logic
  localparam int FC = 0;
  localparam int FZ = 1;
  localparam int FN = 2;
  localparam int FV = 3;
  localparam int FS = 4;
  localparam int FH = 5;

  localparam logic [SW-1:0] M_ARITH = SW'(8'h3F);
  localparam logic [SW-1:0] M_LOGIC = SW'(8'h1E);
  localparam logic [SW-1:0] M_SHIFT = SW'(8'h1F);
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          cin,
  input  logic          sub,
  output logic [DW-1:0] sum,
  output logic          c_out,
  output logic          h_out,
  output logic          v_out
);
  localparam int HB  = DW / 2 - 1;
  localparam int MSB = DW - 1;

  function automatic logic half_add(logic x, logic y, logic r);
    return (x & y) | (y & ~r) | (~r & x);
  endfunction

  function automatic logic half_sub(logic x, logic y, logic r);
    return (~x & y) | (y & r) | (r & ~x);
  endfunction

  function automatic logic ovf_add(logic x, logic y, logic r);
    return (x & y & ~r) | (~x & ~y & r);
  endfunction

  function automatic logic ovf_sub(logic x, logic y, logic r);
    return (x & ~y & ~r) | (~x & y & r);
  endfunction

  logic [DW:0] wide;

  always_comb begin
    if (sub) wide = {1'b0, a} - {1'b0, b} - {{DW{1'b0}}, cin};
    else     wide = {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, cin};
  end

  assign sum   = wide[DW-1:0];
  assign c_out = wide[DW];
  assign h_out = sub ? half_sub(a[HB], b[HB], sum[HB]) : half_add(a[HB], b[HB], sum[HB]);
  assign v_out = sub ? ovf_sub(a[MSB], b[MSB], sum[MSB]) : ovf_add(a[MSB], b[MSB], sum[MSB]);
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic #(
  parameter int DW = 8
) (
  input  alu8_pkg::alu_op_e op,
  input  logic [DW-1:0]     a,
  input  logic [DW-1:0]     b,
  output logic [DW-1:0]     res,
  output logic              v_out
);
  import alu8_pkg::*;
  localparam int HALF = DW / 2;
  localparam logic [DW-1:0] SMAX = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] SMIN = {1'b1, {(DW-1){1'b0}}};

  always_comb begin
    res   = '0;
    v_out = 1'b0;
    case (op)
      OP_AND:  res = a & b;
      OP_OR:   res = a | b;
      OP_XOR:  res = a ^ b;
      OP_COM:  res = ~a;
      OP_INC: begin
        res   = a + 1'b1;
        v_out = (a == SMAX);
      end
      OP_DEC: begin
        res   = a - 1'b1;
        v_out = (a == SMIN);
      end
      OP_SWAP: res = {a[HALF-1:0], a[DW-1:HALF]};
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/alu8_shift.sv
module alu8_shift #(
  parameter int DW = 8
) (
  input  alu8_pkg::alu_op_e op,
  input  logic [DW-1:0]     a,
  input  logic              cin,
  output logic [DW-1:0]     res,
  output logic              c_out
);
  import alu8_pkg::*;

  function automatic logic [DW-1:0] move_left(logic [DW-1:0] x, logic fill);
    return {x[DW-2:0], fill};
  endfunction

  function automatic logic [DW-1:0] move_right(logic [DW-1:0] x, logic fill);
    return {fill, x[DW-1:1]};
  endfunction

  logic left;
  assign left = (op == OP_LSL) || (op == OP_ROL);

  always_comb begin
    case (op)
      OP_LSL:  res = move_left(a, 1'b0);
      OP_ROL:  res = move_left(a, cin);
      OP_LSR:  res = move_right(a, 1'b0);
      OP_ROR:  res = move_right(a, cin);
      OP_ASR:  res = move_right(a, a[DW-1]);
      default: res = '0;
    endcase
    c_out = left ? a[DW-1] : a[0];
  end
endmodule

// File: rtl/alu8_core.sv
module alu8_core #(
  parameter int DW = 8
) (
  input  logic [4:0]    op,
  input  logic [DW-1:0] op_a,
  input  logic [DW-1:0] op_b,
  input  logic          carry_in,
  input  logic [7:0]    status_in,
  output logic [DW-1:0] result,
  output logic [7:0]    status_out,
  output logic [7:0]    flag_we
);
  import alu8_pkg::*;

  alu_op_e opc;
  assign opc = alu_op_e'(op);

  // named selection events, also watched by the checker
  logic sel_arith, sel_logic, sel_shift, sub_mode, neg_mode;
  assign sub_mode  = (opc == OP_SUB) || (opc == OP_SBC) || (opc == OP_NEG);
  assign neg_mode  = (opc == OP_NEG);
  assign sel_arith = (opc == OP_ADD) || (opc == OP_ADC) || sub_mode;
  assign sel_shift = (opc == OP_LSL) || (opc == OP_LSR) || (opc == OP_ROL) ||
                     (opc == OP_ROR) || (opc == OP_ASR);
  assign sel_logic = (opc == OP_AND) || (opc == OP_OR) || (opc == OP_XOR) ||
                     (opc == OP_INC) || (opc == OP_DEC);

  logic [DW-1:0] as_a, as_b, as_res, lg_res, sh_res;
  logic as_cin, as_c, as_h, as_v, lg_v, sh_c;

  assign as_a   = neg_mode ? '0 : op_a;
  assign as_b   = neg_mode ? op_a : op_b;
  assign as_cin = ((opc == OP_ADC) || (opc == OP_SBC)) ? carry_in : 1'b0;

  alu8_addsub #(.DW(DW)) u_addsub (
    .a(as_a), .b(as_b), .cin(as_cin), .sub(sub_mode),
    .sum(as_res), .c_out(as_c), .h_out(as_h), .v_out(as_v)
  );

  alu8_logic #(.DW(DW)) u_logic (
    .op(opc), .a(op_a), .b(op_b), .res(lg_res), .v_out(lg_v)
  );

  alu8_shift #(.DW(DW)) u_shift (
    .op(opc), .a(op_a), .cin(carry_in), .res(sh_res), .c_out(sh_c)
  );

  logic [7:0] new_flags;
  logic       res_zero;
  assign res_zero = (result == '0);

  always_comb begin
    result    = '0;
    flag_we   = '0;
    new_flags = '0;
    if (sel_arith) begin
      result        = as_res;
      flag_we       = M_ARITH;
      new_flags[FC] = as_c;
      new_flags[FH] = as_h;
      new_flags[FV] = as_v;
    end else if (sel_logic) begin
      result        = lg_res;
      flag_we       = M_LOGIC;
      new_flags[FV] = lg_v;
    end else if (opc == OP_COM) begin
      result        = lg_res;
      flag_we       = M_SHIFT;
      new_flags[FC] = 1'b1;
    end else if (sel_shift) begin
      result        = sh_res;
      flag_we       = M_SHIFT;
      new_flags[FC] = sh_c;
      new_flags[FV] = result[DW-1] ^ sh_c;
    end else if (opc == OP_SWAP) begin
      result = lg_res;
    end
    new_flags[FN] = result[DW-1];
    new_flags[FZ] = (opc == OP_SBC) ? (res_zero & status_in[FZ]) : res_zero;
    new_flags[FS] = new_flags[FN] ^ new_flags[FV];
  end

  for (genvar i = 0; i < 8; i++) begin : g_merge
    assign status_out[i] = flag_we[i] ? new_flags[i] : status_in[i];
  end
endmodule

module alu8_core_chk #(
  parameter int DW = 8
) (
  input logic [4:0]    op,
  input logic [DW-1:0] op_a,
  input logic [DW-1:0] result,
  input logic [7:0]    status_in,
  input logic [7:0]    status_out,
  input logic [7:0]    flag_we,
  input logic          sel_shift
);
  import alu8_pkg::*;
  localparam int HALF = DW / 2;

  always_comb begin
    for (int i = 0; i < 8; i++) begin
      if (!flag_we[i]) a_r1_keep_bit: assert (status_out[i] == status_in[i]);
    end
    a_r13_ti_untouched: assert (flag_we[7:6] == 2'b00);
    if (flag_we[FS])
      a_r10_sign: assert (status_out[FS] == (status_out[FN] ^ status_out[FV]));
    if (op == OP_SBC && !status_in[FZ])
      a_r4_sbc_zero_sticky: assert (!status_out[FZ]);
    if (op != OP_SBC && flag_we[FZ])
      a_r4_zero: assert (status_out[FZ] == (result == '0));
    if (sel_shift)
      a_r9_shift_v: assert (status_out[FV] == (status_out[FN] ^ status_out[FC]));
    if (op == OP_COM)
      a_r7_com: assert (status_out[FC] && !status_out[FV]);
    if (op == OP_SWAP)
      a_r11_swap: assert (flag_we == 8'h00 && result == {op_a[HALF-1:0], op_a[DW-1:HALF]});
    if (op > 5'd16)
      a_r12_unused: assert (flag_we == 8'h00 && result == '0);
  end
endmodule

bind alu8_core alu8_core_chk #(.DW(DW)) u_chk (
  .op(op), .op_a(op_a), .result(result), .status_in(status_in),
  .status_out(status_out), .flag_we(flag_we), .sel_shift(sel_shift)
);

// File: tb/test_alu8_core.sv
module test_alu8_core;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [4:0] op;
  logic [7:0] op_a, op_b, status_in, result, status_out, flag_we;
  logic       carry_in;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  alu8_core i_alu8_core (
    .op(op), .op_a(op_a), .op_b(op_b), .carry_in(carry_in),
    .status_in(status_in), .result(result), .status_out(status_out),
    .flag_we(flag_we)
  );

  function automatic string req_of(int code);
    case (code)
      0, 1:          return "R2";
      2, 4:          return "R3";
      3:             return "R4";
      5, 6, 7:       return "R5";
      9, 10:         return "R6";
      8:             return "R7";
      11, 12, 13, 14, 15: return "R8";
      16:            return "R11";
      default:       return "R12";
    endcase
  endfunction

  function automatic int sgn(int x);
    return (x > 127) ? x - 256 : x;
  endfunction

  task automatic model(input int code, input int a, input int b, input int ci, input int si,
                       output int er, output int es, output int ew);
    int c = 0, h = 0, v = 0, n, z, s, t, nf;
    er = 0; ew = 0;
    case (code)
      0, 1: begin
        int k = (code == 1) ? ci : 0;
        t = a + b + k; er = t % 256; c = (t > 255);
        h = ((a % 16) + (b % 16) + k) > 15;
        t = sgn(a) + sgn(b) + k; v = (t > 127 || t < -128); ew = 'h3F;
      end
      2, 3, 4: begin
        int x = (code == 4) ? 0 : a;
        int y = (code == 4) ? a : b;
        int k = (code == 3) ? ci : 0;
        t = x - y - k; er = (t + 256) % 256; c = (t < 0);
        h = ((x % 16) - (y % 16) - k) < 0;
        t = sgn(x) - sgn(y) - k; v = (t > 127 || t < -128); ew = 'h3F;
      end
      5:  begin er = a & b; ew = 'h1E; end
      6:  begin er = a | b; ew = 'h1E; end
      7:  begin er = a ^ b; ew = 'h1E; end
      8:  begin er = 255 - a; c = 1; ew = 'h1F; end
      9:  begin er = (a + 1) % 256; v = (a == 127); ew = 'h1E; end
      10: begin er = (a + 255) % 256; v = (a == 128); ew = 'h1E; end
      11: begin er = (a * 2) % 256; c = (a >= 128); ew = 'h1F; end
      12: begin er = a / 2; c = a % 2; ew = 'h1F; end
      13: begin er = (a * 2 + ci) % 256; c = (a >= 128); ew = 'h1F; end
      14: begin er = a / 2 + ci * 128; c = a % 2; ew = 'h1F; end
      15: begin er = a / 2 + (a & 128); c = a % 2; ew = 'h1F; end
      16: begin er = (a % 16) * 16 + a / 16; end
      default: er = 0;
    endcase
    n = (er >= 128);
    if (code >= 11 && code <= 15) v = n ^ c;
    s = n ^ v;
    z = (er == 0);
    if (code == 3) z = z & ((si >> 1) & 1);
    nf = c + 2 * z + 4 * n + 8 * v + 16 * s + 32 * h;
    es = (si & ~ew & 255) | (nf & ew);
  endtask

  task automatic apply(input int code, input int a, input int b, input int ci, input int si,
                       input string tag);
    int er, es, ew;
    @(posedge clk);
    op = 5'(code); op_a = 8'(a); op_b = 8'(b); carry_in = ci[0]; status_in = 8'(si);
    model(code, a, b, ci, si, er, es, ew);
    @(negedge clk);
    checks++;
    if (result !== 8'(er) || status_out !== 8'(es) || flag_we !== 8'(ew)) begin
      fails++;
      $display("FAIL %s op=%0d a=%02h b=%02h cin=%0d sin=%02h: got res=%02h st=%02h we=%02h, exp res=%02h st=%02h we=%02h",
               tag, code, a, b, ci, si, result, status_out, flag_we, er, es, ew);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    checks++; fails++;
    $display("FAIL watchdog: run hung, exp completion");
    finish_run();
  end

  initial begin
    op = '0; op_a = '0; op_b = '0; carry_in = 1'b0; status_in = '0;
    // idle state with all-zero inputs: add of zeros (R1)
    apply(0, 0, 0, 0, 0, "R1");
    // T and I preserved across a flag-writing op (R13)
    apply(0, 8'h10, 8'h20, 0, 8'hC0, "R13");
    // add corners (R2)
    apply(0, 8'h7F, 8'h01, 0, 0, "R2");
    apply(0, 8'hFF, 8'h01, 0, 0, "R2");
    apply(1, 8'h0F, 8'h00, 1, 0, "R2");
    apply(1, 8'h80, 8'h80, 1, 8'hFF, "R2");
    // subtract corners (R3)
    apply(2, 8'h00, 8'h01, 0, 0, "R3");
    apply(2, 8'h80, 8'h01, 0, 0, "R3");
    apply(4, 8'h80, 8'h00, 0, 0, "R3");
    apply(4, 8'h00, 8'h00, 0, 8'h01, "R3");
    // subtract-with-carry zero chaining (R4)
    apply(3, 8'h05, 8'h05, 0, 8'h02, "R4");
    apply(3, 8'h05, 8'h05, 0, 8'h00, "R4");
    apply(3, 8'h06, 8'h05, 1, 8'h02, "R4");
    apply(3, 8'h06, 8'h05, 0, 8'h02, "R4");
    // logic keeps C and H (R5)
    apply(5, 8'hF0, 8'h0F, 0, 8'h21, "R5");
    apply(7, 8'hAA, 8'h55, 0, 8'h29, "R5");
    // inc/dec overflow (R6)
    apply(9, 8'h7F, 0, 0, 0, "R6");
    apply(10, 8'h80, 0, 0, 0, "R6");
    apply(9, 8'hFF, 0, 0, 8'h01, "R6");
    // one's complement (R7)
    apply(8, 8'hFF, 0, 0, 8'h08, "R7");
    // shifts and rotates (R8, R9)
    apply(11, 8'h80, 0, 1, 0, "R8");
    apply(12, 8'h01, 0, 1, 0, "R8");
    apply(13, 8'h40, 0, 1, 0, "R9");
    apply(14, 8'h02, 0, 1, 0, "R9");
    apply(15, 8'h81, 0, 0, 0, "R8");
    // sign flag recomputation (R10)
    apply(2, 8'h7F, 8'hFF, 0, 0, "R10");
    // swap (R11) and unused codes (R12)
    apply(16, 8'hA5, 0, 1, 8'h3F, "R11");
    apply(17, 8'h12, 8'h34, 1, 8'h55, "R12");
    apply(31, 8'hFF, 8'hFF, 1, 8'hAA, "R12");
    // broad pseudo-random sweep over every code (R1)
    for (int k = 0; k < 600; k++)
      apply($urandom % 32, $urandom % 256, $urandom % 256, $urandom % 2, $urandom % 256,
            "R1");
    finish_run();
  end
endmodule